// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs in the master-clock domain beside two clock dividers, called bank A and bank C. Each divider produces one output rising edge every `ratio` master cycles, and both start from the same alignment reset. Because the two ratios need not be integer multiples of each other, their rising edges line up only once per common interval. That interval is the least common multiple L of the two ratios, measured in master cycles. The block drives an active-low marker, `sync_n`. The marker goes low for exactly one period of the faster divided clock, P = min(ratio_a, ratio_c) master cycles, and returns high on the cycle in which both divided clocks rise together. Downstream logic can therefore treat the low window as a warning that the shared edge is one fast period away.

The ratios are live inputs. A change is first seen on some cycle. The block then lets the old configuration run on, holds `sync_n` high, and computes the new interval with an iterative least-common-multiple engine. It adopts the new ratios at the first coincident edge of the old ratios that falls after a fixed settling window. The dividers are expected to switch on that same coincident edge. A control state machine has three states:

- SETTLE: a guard counter runs while the engine works.
- ARMED: the new interval is ready and the block waits for the coincidence.
- TRACK: the pulse is generated.

Its transitions are named as follows:

- retune: any state goes to SETTLE when the clamped request differs from the last request.
- guard expiry: SETTLE goes to ARMED when the guard counter ends.
- adopt: ARMED goes to TRACK on a coincident cycle.

The engine has three states, LOAD, STEP and DONE. A request moves it to STEP. STEP walks the multiples of both ratios until they meet, then moves to DONE.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst_n` is low, and on every cycle from reset release up to and including the adoption cycle, `sync_n` is high.
- R2: A ratio input value of 0 or 1 behaves exactly as 2. A change between two input values that give the same clamped pair is ignored: the pulse pattern continues unbroken.
- R3: While tracking, the pulse pattern repeats every L = lcm(ratio_a, ratio_c) master cycles. The pattern is anchored at the adoption cycle T0, which is a coincident cycle.
- R4: While tracking with unequal ratios, `sync_n` is low exactly on the cycles t > T0 with (t - T0) mod L in [L - P, L - 1], where P = min(ratio_a, ratio_c). This is a single low run of P cycles.
- R5: While tracking with unequal ratios, `sync_n` is high on every coincident cycle (t - T0) mod L = 0.
- R6: When the two clamped ratios are equal, `sync_n` stays low on every tracking cycle after T0.
- R7: When one ratio is an integer multiple of the other, the pulse is still produced as in R4.
- R8: A change seen in cycle tc drives `sync_n` high from cycle tc + 1 until the new configuration is adopted.
- R9: With G = 2^(RATIO_W+1) + 1, the new ratios are adopted on the first cycle t >= tc + G that is a coincident cycle of the ratios in use. Release from reset counts as tc = -1. Coincident cycles are multiples of the current L counted from the current anchor, where the anchor is cycle 0 after reset.
- R10: A change seen while a previous change is still waiting (SETTLE or ARMED) restarts the wait from the new change, which then obeys R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock that also drives both dividers |
| rst_n | input | 1 | Active-low synchronous reset, shared with the dividers' alignment reset |
| ratio_a | input | RATIO_W | Divide ratio of bank A |
| ratio_c | input | RATIO_W | Divide ratio of bank C |
| sync_n | output | 1 | Registered active-low pulse ahead of the shared rising edge |

## Verification
The embedded assertions cover the invariants that hold on every cycle:

- `sync_n` can be low only in TRACK.
- A seen change forces `sync_n` high on the next cycle.
- The interval counter's head agrees with the coincidence detected by the phase lanes.
- The engine has finished before ARMED.
- Each engine result is a common multiple of both ratios.
- Each phase lane stays below its ratio.

Only the bench scenarios can show the exact position and width of every pulse and the exact adoption cycle after a reset, a live change, a restarted change and an ignored change. Those scenarios sweep every ratio pair of the 3-bit configuration and compare each cycle against an arithmetic model built on a Euclidean gcd.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_ARMED  = 2'd1,
        ST_TRACK  = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        ENG_LOAD = 2'd0,
        ENG_STEP = 2'd1,
        ENG_DONE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/csg_phase_track.sv
module csg_phase_track #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] div_a,
    input  logic [RATIO_W-1:0] div_c,
    output logic               coin
);

    logic [1:0] at_zero;

    // One phase lane per monitored bank; lane 0 follows A, lane 1 follows C.
    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            logic [RATIO_W-1:0] div;
            logic [RATIO_W-1:0] ph;

            assign div = (g == 0) ? div_a : div_c;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ph <= '0;
                end else if (ph == div - RATIO_W'(1)) begin
                    ph <= '0;
                end else begin
                    ph <= ph + RATIO_W'(1);
                end
            end

            assign at_zero[g] = (ph == '0);

            // R3: the lane phase never leaves the range of its ratio
            a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
                ph < div);
        end
    endgenerate

    assign coin = &at_zero;

endmodule

// File: rtl/csg_lcm_engine.sv
module csg_lcm_engine
    import csg_pkg::*;
#(
    parameter int RATIO_W = 3,
    parameter int SPAN_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RATIO_W-1:0] in_a,
    input  logic [RATIO_W-1:0] in_c,
    output logic               done,
    output logic [SPAN_W-1:0]  span,
    output logic [RATIO_W-1:0] fast
);

    eng_state_e         eng_q, eng_d;
    logic [RATIO_W-1:0] sa_q, sa_d, sc_q, sc_d;
    logic [SPAN_W-1:0]  ma_q, ma_d, mc_q, mc_d;

    // Next state: walk the multiples of both ratios until they meet.
    always_comb begin
        eng_d = eng_q;
        sa_d  = sa_q;
        sc_d  = sc_q;
        ma_d  = ma_q;
        mc_d  = mc_q;
        if (start || eng_q == ENG_LOAD) begin
            sa_d  = in_a;
            sc_d  = in_c;
            ma_d  = SPAN_W'(in_a);
            mc_d  = SPAN_W'(in_c);
            eng_d = ENG_STEP;
        end else begin
            unique case (eng_q)
                ENG_STEP: begin
                    if (ma_q == mc_q) begin
                        eng_d = ENG_DONE;
                    end else if (ma_q < mc_q) begin
                        ma_d = ma_q + SPAN_W'(sa_q);
                    end else begin
                        mc_d = mc_q + SPAN_W'(sc_q);
                    end
                end
                ENG_DONE: begin
                    eng_d = ENG_DONE;
                end
                default: begin
                    eng_d = ENG_LOAD;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= ENG_LOAD;
        end else begin
            eng_q <= eng_d;
        end
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= '0;
            sc_q <= '0;
            ma_q <= '0;
            mc_q <= '0;
        end else begin
            sa_q <= sa_d;
            sc_q <= sc_d;
            ma_q <= ma_d;
            mc_q <= mc_d;
        end
    end

    // Outputs.
    always_comb begin
        done = (eng_q == ENG_DONE);
        span = ma_q;
        fast = (sa_q < sc_q) ? sa_q : sc_q;
    end

    // R3: a finished result is a common multiple of both ratios
    a_r3_span_common: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q == ENG_DONE) |-> ((ma_q % SPAN_W'(sa_q)) == '0 && (ma_q % SPAN_W'(sc_q)) == '0));

endmodule

// File: rtl/csg_span_window.sv
module csg_span_window #(
    parameter int RATIO_W = 3,
    parameter int SPAN_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adopt,
    input  logic               run_nxt,
    input  logic [SPAN_W-1:0]  new_span,
    input  logic [RATIO_W-1:0] new_fast,
    output logic               sync_n,
    output logic               head
);

    logic [SPAN_W-1:0]  cnt_q, cnt_d;
    logic [SPAN_W-1:0]  span_q, span_d;
    logic [RATIO_W-1:0] fast_q, fast_d;
    logic               track_q;
    logic               low_d;
    logic               sync_q;

    // Next-cycle count and window decision, so the output is a plain flop.
    always_comb begin
        span_d = adopt ? new_span : span_q;
        fast_d = adopt ? new_fast : fast_q;
        if (adopt) begin
            cnt_d = SPAN_W'(1);
        end else if (run_nxt) begin
            cnt_d = (cnt_q == span_q - SPAN_W'(1)) ? '0 : cnt_q + SPAN_W'(1);
        end else begin
            cnt_d = '0;
        end
        low_d = run_nxt && (cnt_d >= span_d - SPAN_W'(fast_d));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            span_q  <= '0;
            fast_q  <= '0;
            track_q <= 1'b0;
            sync_q  <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            span_q  <= span_d;
            fast_q  <= fast_d;
            track_q <= run_nxt;
            sync_q  <= !low_d;
        end
    end

    assign sync_n = sync_q;
    assign head   = (cnt_q == '0);

    // R3: the interval counter stays inside the adopted interval
    a_r3_count_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        track_q |-> (cnt_q < span_q));

endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
    import csg_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_a,
    input  logic [RATIO_W-1:0] ratio_c,
    output logic               sync_n
);

    localparam int SPAN_W  = 2 * RATIO_W;
    localparam int GUARD   = 1 << (RATIO_W + 1);
    localparam int GUARD_W = $clog2(GUARD) + 1;

    function automatic logic [RATIO_W-1:0] floor_two(input logic [RATIO_W-1:0] r);
        return (r < RATIO_W'(2)) ? RATIO_W'(2) : r;
    endfunction

    trk_state_e         state_q, state_d;
    logic [RATIO_W-1:0] req_a, req_c;
    logic [RATIO_W-1:0] pend_a, pend_c;
    logic [RATIO_W-1:0] cur_a, cur_c;
    logic [GUARD_W-1:0] gcnt;
    logic               chg;
    logic               adopt;
    logic               coin;
    logic               head;
    logic               eng_done;
    logic [SPAN_W-1:0]  eng_span;
    logic [RATIO_W-1:0] eng_fast;

    assign req_a = floor_two(ratio_a);
    assign req_c = floor_two(ratio_c);
    assign chg   = (req_a != pend_a) || (req_c != pend_c);

    // Transitions: retune, guard expiry, adopt.
    always_comb begin
        state_d = state_q;
        adopt   = 1'b0;
        if (chg) begin
            state_d = ST_SETTLE;
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (gcnt == GUARD_W'(GUARD - 1)) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (coin) begin
                        state_d = ST_TRACK;
                        adopt   = 1'b1;
                    end
                end
                ST_TRACK: begin
                    state_d = ST_TRACK;
                end
                default: begin
                    state_d = ST_SETTLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request, current ratio and guard registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a <= req_a;
            pend_c <= req_c;
            cur_a  <= req_a;
            cur_c  <= req_c;
            gcnt   <= '0;
        end else begin
            if (chg) begin
                pend_a <= req_a;
                pend_c <= req_c;
            end
            if (chg) begin
                gcnt <= '0;
            end else if (state_q == ST_SETTLE) begin
                gcnt <= gcnt + GUARD_W'(1);
            end
            if (adopt) begin
                cur_a <= pend_a;
                cur_c <= pend_c;
            end
        end
    end

    csg_phase_track #(
        .RATIO_W (RATIO_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .div_a (cur_a),
        .div_c (cur_c),
        .coin  (coin)
    );

    csg_lcm_engine #(
        .RATIO_W (RATIO_W),
        .SPAN_W  (SPAN_W)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (chg),
        .in_a  (req_a),
        .in_c  (req_c),
        .done  (eng_done),
        .span  (eng_span),
        .fast  (eng_fast)
    );

    csg_span_window #(
        .RATIO_W (RATIO_W),
        .SPAN_W  (SPAN_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .adopt    (adopt),
        .run_nxt  (state_d == ST_TRACK),
        .new_span (eng_span),
        .new_fast (eng_fast),
        .sync_n   (sync_n),
        .head     (head)
    );

    // R8: the marker can be low only while tracking
    a_r8_low_only_tracking: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> (state_q == ST_TRACK));

    // R8: a seen change forces the marker high on the next cycle
    a_r8_drop_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> sync_n);

    // R3: interval head and detected coincidence agree while tracking
    a_r3_head_on_coin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |-> (head == coin));

    // R9: the engine has its result before the block waits for a coincidence
    a_r9_armed_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> eng_done);

endmodule

// File: tb/tb_coin_sync_gen.sv
module tb_coin_sync_gen;

    localparam int CLK_PERIOD = 10;
    localparam int RATIO_W    = 3;
    localparam int G_DELAY    = (1 << (RATIO_W + 1)) + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [RATIO_W-1:0] ratio_a = 3'd2;
    logic [RATIO_W-1:0] ratio_c = 3'd2;
    logic               sync_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coin_sync_gen #(.RATIO_W(RATIO_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_a (ratio_a),
        .ratio_c (ratio_c),
        .sync_n  (sync_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    int t;

    // Model of the requirements.
    int m_pa, m_pc;          // last clamped request
    int m_ca, m_cc;          // ratios in use
    int m_anchor, m_t0, m_span, m_fast, m_tch;
    bit m_wait, m_track, m_from_reset, m_restart, m_live, m_live_rs, m_clamp;

    function automatic int fl2(input int r);
        return (r < 2) ? 2 : r;
    endfunction

    function automatic int gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int r = x % y;
            x = y;
            y = r;
        end
        return x;
    endfunction

    function automatic int lcm(input int a, input int b);
        return (a / gcd(a, b)) * b;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d sync_n actual=%0b expected=%0b", tag, t, act, exp);
        end
    endtask

    task automatic eval_cycle();
        bit    exp = 1'b1;
        string tag;
        if (m_track && t > m_t0) begin
            int off = (t - m_t0) % m_span;
            exp = !(off >= m_span - m_fast);
            if (m_clamp)                                   tag = "R2";
            else if (m_ca == m_cc)                         tag = "R6";
            else if (m_live && t <= m_t0 + m_span)         tag = m_live_rs ? "R10" : "R9";
            else if (off == 0)                             tag = "R5";
            else if (m_ca % m_cc == 0 || m_cc % m_ca == 0) tag = "R7";
            else if (off == m_span - m_fast)               tag = "R3";
            else                                           tag = "R4";
        end else begin
            tag = m_from_reset ? "R1" : (m_restart ? "R10" : "R8");
        end
        check(sync_n, exp, tag);
    endtask

    task automatic end_cycle();
        if (m_wait && t >= m_tch + G_DELAY &&
            ((t - m_anchor) % lcm(m_ca, m_cc)) == 0) begin
            m_ca      = m_pa;
            m_cc      = m_pc;
            m_anchor  = t;
            m_t0      = t;
            m_span    = lcm(m_ca, m_cc);
            m_fast    = (m_ca < m_cc) ? m_ca : m_cc;
            m_track   = 1'b1;
            m_wait    = 1'b0;
            m_live    = !m_from_reset;
            m_live_rs = m_restart;
        end
    endtask

    task automatic next();
        end_cycle();
        @(posedge clk);
        @(negedge clk);
        t++;
        eval_cycle();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) next();
    endtask

    task automatic apply_reset(input int a, input int c);
        @(negedge clk);
        rst_n   = 1'b0;
        ratio_a = RATIO_W'(a);
        ratio_c = RATIO_W'(c);
        repeat (3) @(negedge clk);
        // R1: marker high while reset is held
        check(sync_n, 1'b1, "R1");
        rst_n        = 1'b1;
        t            = 0;
        m_pa         = fl2(a);
        m_pc         = fl2(c);
        m_ca         = m_pa;
        m_cc         = m_pc;
        m_anchor     = 0;
        m_tch        = -1;
        m_wait       = 1'b1;
        m_track      = 1'b0;
        m_from_reset = 1'b1;
        m_restart    = 1'b0;
        m_live       = 1'b0;
        m_live_rs    = 1'b0;
        m_clamp      = (a < 2) || (c < 2);
        eval_cycle();
    endtask

    task automatic change(input int a, input int c);
        int na = fl2(a);
        int nc = fl2(c);
        ratio_a = RATIO_W'(a);
        ratio_c = RATIO_W'(c);
        if (na != m_pa || nc != m_pc) begin
            m_restart    = m_wait;
            m_from_reset = 1'b0;
            m_pa         = na;
            m_pc         = nc;
            m_wait       = 1'b1;
            m_tch        = t;
            m_track      = 1'b0;
        end
    endtask

    int chain_a [7] = '{4, 2, 7, 3, 6, 5, 7};
    int chain_c [7] = '{6, 6, 3, 3, 4, 2, 6};

    initial begin
        // Reset sweep over every ratio pair, clamped values included (R1..R7, R2).
        for (int a = 0; a < 8; a++) begin
            for (int c = 0; c < 8; c++) begin
                apply_reset(a, c);
                run(G_DELAY + 3 * lcm(fl2(a), fl2(c)) + 4);
            end
        end

        // Live changes through a chain of pairs (R8, R9).
        apply_reset(5, 7);
        run(G_DELAY + 2 * 35);
        for (int k = 0; k < 7; k++) begin
            int old_span = m_span;
            change(chain_a[k], chain_c[k]);
            run(G_DELAY + 2 * old_span + 3 * lcm(chain_a[k], chain_c[k]) + 3);
        end

        // Change while a previous change still waits (R10).
        change(4, 5);
        run(5);
        change(6, 7);
        run(G_DELAY + 2 * 20 + 3 * 42 + 3);
        change(2, 7);
        run(9);
        change(3, 4);
        run(G_DELAY + 2 * 42 + 3 * 12 + 3);

        // Changes that clamp to the same pair are ignored (R2).
        change(2, 5);
        run(G_DELAY + 2 * 12 + 3 * 10 + 3);
        m_clamp = 1'b1;
        change(1, 5);
        run(23);
        change(0, 5);
        run(31);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog cycle limit reached actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule